// File: doc/BRIEF.md
# Four-Channel 12-Bit DAC Loader

This block sits on a byte-wide register bus and feeds a serial four-channel 12-bit digital-to-analog converter. Software first places the low eight data bits in a staging register. A second write, to the neighbouring offset, supplies the upper four data bits and a two-bit channel number. That write latches the full value and starts a 16-bit serial transfer to the converter. While the transfer runs, bit 7 of the status register reads 1.

Each channel has an output register that models the converter's analog latch. The transfer alone does not change that register. A read of the high-byte offset, made after busy has dropped, commits the transferred value to the channel that the load selected. Until that read, every channel holds its last committed value, which is zero after reset. A high-byte write made while a transfer is running is dropped. The staged low byte is kept until software writes a new one.

Top module: `dac_load_if`

## Requirements
- R1: After reset, every channel output is 0, the status read (offset 0x4) returns 0x00, the serial sync output is high and the serial clock is low.
- R2: A write to offset 0x4 stages the low data byte. A write to offset 0x5 while idle latches channel = data[7:6] and value = {data[3:0], staged low byte}. From the next cycle, bit 7 of the offset 0x4 read returns 1 (busy) and bits 6:0 return 0.
- R3: Busy stays high for exactly 16 × BIT_CYCLES clock cycles after the accepted high-byte write.
- R4: During a transfer, sync is low and the serial data shows a 16-bit frame {channel[1:0], 2'b00, value[11:0]}, most significant bit first. Each bit is stable on one rising edge of the serial clock.
- R5: A read of offset 0x5 made after busy has cleared, with a load pending, sets the selected channel's output to the loaded value in the next cycle. The other channels do not change.
- R6: A channel output changes only through a commit read. Writes and transfers leave every output unchanged.
- R7: A high-byte write made while busy is ignored. The running frame, the busy time and the value that is later committed all belong to the first load.
- R8: A read of offset 0x5 made while busy commits nothing. A further read of offset 0x5 after a commit, with no new load, changes nothing.
- R9: The staged low byte is kept across loads. A high-byte write with no new low-byte write reuses the last staged byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a read of 0x5 is the commit |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0x4: status, 0x5: last accepted high byte, others 0) |
| ser_clk | output | 1 | Serial clock to the converter |
| ser_dat | output | 1 | Serial data, MSB first |
| ser_sync_n | output | 1 | Active-low frame sync |
| dac_out | output | 48 | Channel outputs, channel n at bits [12n+11:12n] |

## Verification
A wrong staged byte, channel or pending flag shows up at the serial pins within the next transfer. If the serial pins hide it, it shows on `dac_out` one cycle after the commit read. A wrong busy counter changes how many cycles the status bit stays set, so the bench counts those cycles on every load. The bench also checks that no output moves before the commit read, so a premature update shows in the cycle it happens.

// File: rtl/dacl_pkg.sv
package dacl_pkg;
    localparam int DATA_W  = 12;
    localparam int CH_W    = 2;
    localparam int FRAME_W = 16;
    localparam logic [3:0] OFS_LO = 4'h4;
    localparam logic [3:0] OFS_HI = 4'h5;

    typedef struct packed {
        logic [CH_W-1:0]   ch;
        logic [DATA_W-1:0] val;
    } load_t;
endpackage

// File: rtl/dacl_shifter.sv
module dacl_shifter #(
    parameter int BIT_CYCLES = 4,
    parameter int FRAME_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               busy,
    output logic               sclk,
    output logic               sdat
);
    localparam int CW   = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
    localparam int BW   = $clog2(FRAME_W);
    localparam int HALF = BIT_CYCLES / 2;

    typedef struct packed {
        logic               busy;
        logic               sclk;
        logic [CW-1:0]      cyc;
        logic [BW-1:0]      bitn;
        logic [FRAME_W-1:0] sh;
    } sh_state_t;

    sh_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.cyc  = '0;
                s_d.bitn = '0;
                s_d.sh   = frame;
            end
        end else if (s_q.cyc == CW'(BIT_CYCLES - 1)) begin
            s_d.cyc = '0;
            if (s_q.bitn == BW'(FRAME_W - 1)) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.bitn = s_q.bitn + 1'b1;
                s_d.sh   = {s_q.sh[FRAME_W-2:0], 1'b0};
            end
        end else begin
            s_d.cyc = s_q.cyc + 1'b1;
        end
        s_d.sclk = s_d.busy && (s_d.cyc >= CW'(HALF));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign sclk = s_q.sclk;
    assign sdat = s_q.busy & s_q.sh[FRAME_W-1];
endmodule

// File: rtl/dacl_bank.sv
module dacl_bank #(
    parameter int NCH    = 4,
    parameter int DATA_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic [$clog2(NCH)-1:0]  sel,
    input  logic [DATA_W-1:0]       val,
    output logic [NCH*DATA_W-1:0]   out_flat
);
    logic [DATA_W-1:0] reg_d [NCH];
    logic [DATA_W-1:0] reg_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_comb begin
            reg_d[g] = reg_q[g];
            if (upd && (sel == g)) reg_d[g] = val;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) reg_q[g] <= '0;
            else        reg_q[g] <= reg_d[g];
        end
        assign out_flat[g*DATA_W +: DATA_W] = reg_q[g];
    end
endmodule

// File: rtl/dac_load_if.sv
module dac_load_if #(
    parameter int BIT_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        ser_clk,
    output logic        ser_dat,
    output logic        ser_sync_n,
    output logic [47:0] dac_out
);
    import dacl_pkg::*;
    localparam int NCH = 1 << CH_W;

    typedef struct packed {
        logic [7:0] lo;
        logic [7:0] hi;
        load_t      ld;
        logic       pend;
    } if_state_t;

    if_state_t r_d, r_q;
    logic busy, start, commit;

    always_comb begin
        r_d    = r_q;
        start  = 1'b0;
        commit = 1'b0;
        if (bus_wr && bus_addr == OFS_LO) r_d.lo = bus_wdata;
        if (bus_wr && bus_addr == OFS_HI && !busy) begin
            r_d.hi     = bus_wdata;
            r_d.ld.ch  = bus_wdata[7:6];
            r_d.ld.val = {bus_wdata[3:0], r_q.lo};
            r_d.pend   = 1'b1;
            start      = 1'b1;
        end else if (bus_rd && bus_addr == OFS_HI && !busy && r_q.pend) begin
            commit   = 1'b1;
            r_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_LO)      bus_rdata = {busy, 7'b0};
        else if (bus_addr == OFS_HI) bus_rdata = r_q.hi;
    end

    dacl_shifter #(.BIT_CYCLES(BIT_CYCLES), .FRAME_W(FRAME_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .frame ({r_d.ld.ch, 2'b00, r_d.ld.val}),
        .busy  (busy),
        .sclk  (ser_clk),
        .sdat  (ser_dat)
    );

    dacl_bank #(.NCH(NCH), .DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (commit),
        .sel      (r_q.ld.ch),
        .val      (r_q.ld.val),
        .out_flat (dac_out)
    );

    assign ser_sync_n = ~busy;
endmodule

// File: rtl/dacl_chk.sv
module dacl_chk #(
    parameter int BIT_CYCLES = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic        busy,
    input logic        pend,
    input logic [13:0] ld,
    input logic        ser_clk,
    input logic        ser_sync_n,
    input logic [47:0] dac_out
);
    logic [15:0] len_q;
    always_ff @(posedge clk) begin
        if (!rst_n)    len_q <= '0;
        else if (busy) len_q <= len_q + 1'b1;
        else           len_q <= '0;
    end

    assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'h5 && !busy) |=> busy);

    assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(busy)) |-> (len_q == 16'(16 * BIT_CYCLES)));

    assert_idle_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ser_sync_n && !ser_clk));

    assert_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == 4'h5 && !busy && pend) |=> !pend);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == 4'h5 && !busy && pend) |=> $stable(dac_out));

    assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ld));
endmodule

bind dac_load_if dacl_chk #(.BIT_CYCLES(BIT_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .busy       (busy),
    .pend       (r_q.pend),
    .ld         (r_q.ld),
    .ser_clk    (ser_clk),
    .ser_sync_n (ser_sync_n),
    .dac_out    (dac_out)
);

// File: tb/sim_dac_load_if.sv
`timescale 1ns/1ps
module sim_dac_load_if;
    localparam int B = 4;
    localparam int L = 16 * B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ser_clk, ser_dat, ser_sync_n;
    logic [47:0] dac_out;

    always #2.5 clk = ~clk;

    dac_load_if #(.BIT_CYCLES(B)) u0 (.*);

    int total = 0, bad = 0;
    logic [11:0] model [4];
    logic [15:0] cap;
    int          capn;
    logic        done = 1'b0;

    always @(posedge ser_clk) begin
        cap  <= {cap[14:0], ser_dat};
        capn <= capn + 1;
    end

    // {lo, hi, expected channel (4 bits), expected value (12 bits)}
    localparam logic [31:0] VEC [5] = '{
        32'hFF0F_0FFF, 32'h2341_1123, 32'h5C8A_2A5C,
        32'h00C0_3000, 32'hA0F7_37A0 };

    function automatic logic [47:0] flat();
        return {model[3], model[2], model[1], model[0]};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic status(output logic [7:0] d);
        bus_addr = 4'h4;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [7:0] s;
        n = 0;
        status(s);
        while (s[7] && n < 10000) begin
            n++;
            @(negedge clk);
            status(s);
        end
    endtask

    task automatic load(input logic [7:0] hi, input logic [1:0] ch, input logic [11:0] v,
                        input string tag);
        int n;
        logic [7:0] s;
        capn = 0;
        wr(4'h5, hi);
        status(s);
        check({tag, " R2 busy/status"}, s, 8'h80);
        wait_idle(n);
        check({tag, " R3 busy length"}, n, L);
        check({tag, " R4 frame"}, {capn[15:0], cap}, {16'd16, ch, 2'b00, v});
        check({tag, " R6 no change before commit"}, dac_out, flat());
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 4; i++) model[i] = '0;
        cap = '0; capn = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        status(d);
        check("R1 status", d, 8'h00);
        check("R1 outputs", dac_out, 48'h0);
        check("R1 serial idle", {ser_sync_n, ser_clk}, 2'b10);

        // table-driven loads and commits (R2 R3 R4 R5)
        for (int i = 0; i < 5; i++) begin
            logic [7:0] lo, hi;
            logic [1:0] ch;
            logic [11:0] v;
            {lo, hi} = VEC[i][31:16];
            ch = VEC[i][13:12];
            v  = VEC[i][11:0];
            wr(4'h4, lo);
            load(hi, ch, v, "vec");
            rd(4'h5, d);
            check("R2 high readback", d, hi);
            model[ch] = v;
            check("R5 commit", dac_out, flat());
        end

        // R8: read while busy commits nothing
        wr(4'h4, 8'h11);
        capn = 0;
        wr(4'h5, 8'h42);
        rd(4'h5, d);
        check("R8 read while busy", dac_out, flat());
        begin
            int n;
            wait_idle(n);
        end
        check("R8 still held after busy", dac_out, flat());
        rd(4'h5, d);
        model[1] = 12'h211;
        check("R5 commit ch1", dac_out, flat());
        // R8: second read with nothing pending, after a new low byte
        wr(4'h4, 8'hEE);
        rd(4'h5, d);
        check("R8 no re-commit", dac_out, flat());

        // R7: high write during busy ignored
        wr(4'h4, 8'h3C);
        capn = 0;
        wr(4'h5, 8'h05);
        repeat (3) @(negedge clk);
        wr(4'h5, 8'hC9);
        begin
            int n;
            wait_idle(n);
            check("R7 busy length unchanged", n, L - 5);
        end
        check("R7 frame of first load", {capn[15:0], cap}, {16'd16, 2'd0, 2'b00, 12'h53C});
        rd(4'h5, d);
        check("R7 high readback of first", d, 8'h05);
        model[0] = 12'h53C;
        check("R7 committed first load", dac_out, flat());

        // R9: staged low byte kept across loads
        load(8'h87, 2'd2, 12'h73C, "R9");
        rd(4'h5, d);
        model[2] = 12'h73C;
        check("R9 reused low byte", dac_out, flat());

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule